// File: doc/BRIEF.md
# Paged Write Address Generator

This block converts the 8-bit word address that a serial memory interface receives into the 9-bit internal address of a 272-byte array, arranged as 17 pages of 16 bytes. It produces the internal address for every data byte of a single-byte write or a multi-byte page write. During a page write the in-page offset advances after each accepted byte and wraps inside the page, while the page number stays fixed.

Addressing is not a plain linear map. Word addresses below the all-ones value map straight through. The all-ones word address (FFh) selects internal location 100h, which is the first byte of page 16. Internal location 0FFh and locations 101h to 10Fh can be reached only by walking a page write into them. The block flags those page-only locations. It also flags the control byte window 080h to 08Fh for downstream write handling. When a page write accepts more bytes than a page holds, the block flags the overrun.

A controller state machine has four named states. IDLE means no transfer is open. BYTE means a single-byte write is open and its one byte is still due. SPENT means the single byte has been taken, so further bytes are not legal. PAGE means a page write is open. Its transitions are the following. `load` moves any state to BYTE or PAGE, selected by `page_mode`. `stop` without `load` moves any state to IDLE. `byte_ack` without `load` or `stop` moves BYTE to SPENT. Every other input combination holds the state.

Top module: `page_addr_gen`

## Requirements
- R1: After reset the block is in IDLE: `int_addr` is 000h, and `wr_legal`, `page_only`, `ctrl_hit` and `overrun` are 0.
- R2: A `load` with `word_addr` in 00h..FEh makes `int_addr` equal to `word_addr` on the next cycle, in both write modes.
- R3: A `load` with `word_addr` = FFh makes `int_addr` equal to 100h on the next cycle, in both write modes. In a page write this places the transfer on page 16 at offset 0.
- R4: In a page write, each `byte_ack` raises the low 4 bits of `int_addr` by one on the next cycle, wrapping from 15 to 0. Bits 8..4 (the page number) never change.
- R5: In a single-byte write, `wr_legal` is 1 until the first `byte_ack`. After that byte, `wr_legal` is 0 and `int_addr` is unchanged.
- R6: `page_only` is 1 exactly when `int_addr` is 0FFh or lies in 101h..10Fh. A single-byte write never yields `page_only` = 1.
- R7: `ctrl_hit` is 1 exactly when `int_addr` lies in 080h..08Fh.
- R8: `overrun` is 0 for the first 16 bytes of a page write. It is 1 once 16 bytes have been accepted, and it stays 1 while further bytes wrap over the page.
- R9: `stop` without `load` returns the block to IDLE. In IDLE, `wr_legal` and `overrun` are 0 and `int_addr` holds its last value.
- R10: `load` takes priority over `stop` and `byte_ack` in the same cycle. `stop` takes priority over `byte_ack`: that byte is not counted.
- R11: A `byte_ack` in IDLE has no effect on `int_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Opens a write and latches the starting word address |
| page_mode | input | 1 | With `load`: 1 opens a page write, 0 opens a single-byte write |
| word_addr | input | 8 | Word address received from the bus |
| byte_ack | input | 1 | One data byte has been accepted |
| stop | input | 1 | Ends the current transfer |
| int_addr | output | 9 | Internal array address of the current byte |
| wr_legal | output | 1 | The current byte may be written |
| page_only | output | 1 | The current location cannot be reached by a single-byte write |
| ctrl_hit | output | 1 | The current location is a control byte |
| overrun | output | 1 | The page write has accepted more bytes than a page holds |

## Verification
The bench builds the block with its default parameters: 8-bit word addresses and 17 pages of 16 bytes. This size allows a full sweep. Every one of the 256 word addresses is loaded in both write modes. Each page write is then walked for 17 bytes, so every offset wraps and every page passes the overrun point. The sweep therefore reaches the FFh remap, every page-only location and the whole control window. Directed sequences cover the priority of `load`, `stop` and `byte_ack`, and bytes arriving in IDLE.

// File: rtl/pwag_pkg.sv
package pwag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE  = 2'd1,
        ST_SPENT = 2'd2,
        ST_PAGE  = 2'd3
    } pw_state_e;
endpackage

// File: rtl/pwag_remap.sv
// Maps a bus word address onto a page number and an in-page offset.
// The all-ones word address is folded onto the first byte of the last page.
module pwag_remap #(
    parameter int WADDR_W   = 8,
    parameter int NUM_PAGES = 17,
    parameter int PAGE_W    = 5,
    parameter int OFS_W     = 4
) (
    input  logic [WADDR_W-1:0] word_addr,
    output logic [PAGE_W-1:0]  page,
    output logic [OFS_W-1:0]   ofs
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    always_comb begin
        if (word_addr == {WADDR_W{1'b1}}) begin
            page = LAST_PAGE;
            ofs  = '0;
        end else begin
            page = PAGE_W'(word_addr >> OFS_W);
            ofs  = word_addr[OFS_W-1:0];
        end
    end
endmodule

// File: rtl/pwag_ofs_ctr.sv
// In-page offset counter with wrap, plus a saturating count of accepted bytes.
module pwag_ofs_ctr #(
    parameter int PAGE_BYTES = 16,
    parameter int OFS_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [OFS_W-1:0] ofs_init,
    input  logic             step,
    output logic [OFS_W-1:0] ofs_q,
    output logic             full
);
    localparam int            CNT_W    = OFS_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);
    localparam logic [OFS_W-1:0] OFS_TOP = OFS_W'(PAGE_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
            cnt_q <= '0;
        end else if (init) begin
            ofs_q <= ofs_init;
            cnt_q <= '0;
        end else if (step) begin
            ofs_q <= (ofs_q == OFS_TOP) ? '0 : ofs_q + 1'b1;
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pwag_decode.sv
// Classifies an internal address: page-only locations and the control window.
module pwag_decode #(
    parameter int          IADDR_W     = 9,
    parameter int          DIRECT_TOP  = 255,
    parameter int          ARRAY_BYTES = 272,
    parameter int          CTRL_LO     = 128,
    parameter int          CTRL_HI     = 143
) (
    input  logic [IADDR_W-1:0] addr,
    output logic               page_only,
    output logic               ctrl_hit
);
    localparam logic [IADDR_W-1:0] HOLE_A   = IADDR_W'(DIRECT_TOP);
    localparam logic [IADDR_W-1:0] REMAP_AT = IADDR_W'(DIRECT_TOP + 1);
    localparam logic [IADDR_W-1:0] END_AT   = IADDR_W'(ARRAY_BYTES);
    localparam logic [IADDR_W-1:0] C_LO     = IADDR_W'(CTRL_LO);
    localparam logic [IADDR_W-1:0] C_HI     = IADDR_W'(CTRL_HI);

    always_comb begin
        page_only = (addr == HOLE_A) || ((addr > REMAP_AT) && (addr < END_AT));
        ctrl_hit  = (addr >= C_LO) && (addr <= C_HI);
    end
endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen
    import pwag_pkg::*;
#(
    parameter int WADDR_W    = 8,
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 17,
    parameter int CTRL_LO    = 128,
    parameter int CTRL_HI    = 143
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 page_mode,
    input  logic [WADDR_W-1:0]   word_addr,
    input  logic                 byte_ack,
    input  logic                 stop,
    output logic [$clog2(NUM_PAGES)+$clog2(PAGE_BYTES)-1:0] int_addr,
    output logic                 wr_legal,
    output logic                 page_only,
    output logic                 ctrl_hit,
    output logic                 overrun
);
    localparam int OFS_W       = $clog2(PAGE_BYTES);
    localparam int PAGE_W      = $clog2(NUM_PAGES);
    localparam int IADDR_W     = PAGE_W + OFS_W;
    localparam int ARRAY_BYTES = NUM_PAGES * PAGE_BYTES;
    localparam int DIRECT_TOP  = (1 << WADDR_W) - 1;

    pw_state_e         state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] page_init;
    logic [OFS_W-1:0]  ofs_init;
    logic [OFS_W-1:0]  ofs_q;
    logic              count_full;
    logic              step;

    pwag_remap #(
        .WADDR_W   (WADDR_W),
        .NUM_PAGES (NUM_PAGES),
        .PAGE_W    (PAGE_W),
        .OFS_W     (OFS_W)
    ) u_remap (
        .word_addr (word_addr),
        .page      (page_init),
        .ofs       (ofs_init)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic: load beats stop, stop beats byte_ack
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = page_mode ? ST_PAGE : ST_BYTE;
        end else if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BYTE:  state_d = byte_ack ? ST_SPENT : ST_BYTE;
                ST_SPENT: state_d = ST_SPENT;
                ST_PAGE:  state_d = ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Page register: fixed for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            page_q <= '0;
        else if (load)
            page_q <= page_init;
    end

    assign step = byte_ack && !load && !stop && (state_q == ST_PAGE);

    pwag_ofs_ctr #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFS_W      (OFS_W)
    ) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (load),
        .ofs_init (ofs_init),
        .step     (step),
        .ofs_q    (ofs_q),
        .full     (count_full)
    );

    assign int_addr = {page_q, ofs_q};

    pwag_decode #(
        .IADDR_W     (IADDR_W),
        .DIRECT_TOP  (DIRECT_TOP),
        .ARRAY_BYTES (ARRAY_BYTES),
        .CTRL_LO     (CTRL_LO),
        .CTRL_HI     (CTRL_HI)
    ) u_dec (
        .addr      (int_addr),
        .page_only (page_only),
        .ctrl_hit  (ctrl_hit)
    );

    // Outputs from the state
    always_comb begin
        wr_legal = 1'b0;
        overrun  = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_legal = 1'b0;
            ST_BYTE:  wr_legal = 1'b1;
            ST_SPENT: wr_legal = 1'b0;
            ST_PAGE: begin
                wr_legal = 1'b1;
                overrun  = count_full;
            end
            default:  wr_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/page_addr_gen_chk.sv
module page_addr_gen_chk
    import pwag_pkg::*;
#(
    parameter int WADDR_W = 8,
    parameter int OFS_W   = 4,
    parameter int IADDR_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic               page_mode,
    input logic [WADDR_W-1:0] word_addr,
    input logic               byte_ack,
    input logic               stop,
    input pw_state_e          st,
    input logic [IADDR_W-1:0] int_addr,
    input logic               wr_legal,
    input logic               page_only,
    input logic               ctrl_hit,
    input logic               overrun
);
    localparam logic [IADDR_W-1:0] FOLD_ADDR = IADDR_W'(1 << WADDR_W);

    a_r2_direct_map: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (word_addr != {WADDR_W{1'b1}})) |=> (int_addr == IADDR_W'($past(word_addr))));

    a_r3_fold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (word_addr == {WADDR_W{1'b1}})) |=> (int_addr == FOLD_ADDR));

    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PAGE) && byte_ack && !load && !stop) |=> $stable(int_addr[IADDR_W-1:OFS_W]));

    a_r5_byte_spent: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BYTE) && byte_ack && !load && !stop) |=> (!wr_legal && $stable(int_addr)));

    a_r6_byte_reachable: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !page_mode) |=> !page_only);

    a_r7_ctrl_window: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ((word_addr >> OFS_W) == WADDR_W'(8))) |=> ctrl_hit);

    a_r8_overrun_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(byte_ack));

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> (!wr_legal && !overrun && $stable(int_addr)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && !load) |=> $stable(int_addr));
endmodule

bind page_addr_gen page_addr_gen_chk #(
    .WADDR_W (WADDR_W),
    .OFS_W   (OFS_W),
    .IADDR_W (IADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .page_mode (page_mode),
    .word_addr (word_addr),
    .byte_ack  (byte_ack),
    .stop      (stop),
    .st        (state_q),
    .int_addr  (int_addr),
    .wr_legal  (wr_legal),
    .page_only (page_only),
    .ctrl_hit  (ctrl_hit),
    .overrun   (overrun)
);

// File: tb/test_page_addr_gen.sv
`timescale 1ns/1ps
module test_page_addr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       page_mode = 1'b0;
    logic [7:0] word_addr = '0;
    logic       byte_ack = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] int_addr;
    logic       wr_legal, page_only, ctrl_hit, overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    page_addr_gen i_page_addr_gen (
        .clk(clk), .rst_n(rst_n), .load(load), .page_mode(page_mode),
        .word_addr(word_addr), .byte_ack(byte_ack), .stop(stop),
        .int_addr(int_addr), .wr_legal(wr_legal), .page_only(page_only),
        .ctrl_hit(ctrl_hit), .overrun(overrun)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drives one cycle of inputs, lets the edge take them, then releases them
    task automatic cyc(input logic ld, input logic pm, input int wa,
                       input logic ack, input logic stp);
        load = ld; page_mode = pm; word_addr = 8'(wa);
        byte_ack = ack; stop = stp;
        @(posedge clk);
        #2;
        load = 1'b0; byte_ack = 1'b0; stop = 1'b0;
        #1;
    endtask

    function automatic int base_of(input int wa);
        return (wa == 255) ? 256 : wa;
    endfunction
    function automatic int po_of(input int a);
        return ((a == 255) || (a >= 257 && a <= 271)) ? 1 : 0;
    endfunction
    function automatic int ctl_of(input int a);
        return (a >= 128 && a <= 143) ? 1 : 0;
    endfunction

    initial begin
        #(200000 * 20);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #25;
        // R1 reset state
        chk(int_addr, 0, "R1 addr");
        chk(wr_legal, 0, "R1 wr_legal");
        chk(page_only, 0, "R1 page_only");
        chk(ctrl_hit, 0, "R1 ctrl_hit");
        chk(overrun, 0, "R1 overrun");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int wa = 0; wa < 256; wa++) begin
            for (int pm = 0; pm < 2; pm++) begin
                int b;
                b = base_of(wa);
                cyc(1'b1, pm[0], wa, 1'b0, 1'b0);
                chk(int_addr, b, (wa == 255) ? "R3 fold" : "R2 direct");
                chk(wr_legal, 1, "R5 open legal");
                chk(page_only, po_of(b), "R6 page_only at load");
                chk(ctrl_hit, ctl_of(b), "R7 ctrl at load");
                if (pm == 1) begin
                    for (int k = 1; k <= 17; k++) begin
                        int a;
                        a = (b / 16) * 16 + ((b % 16) + k) % 16;
                        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
                        chk(int_addr, a, "R4 walk");
                        chk(overrun, (k >= 16) ? 1 : 0, "R8 overrun");
                        chk(page_only, po_of(a), "R6 page_only walk");
                        chk(ctrl_hit, ctl_of(a), "R7 ctrl walk");
                    end
                end else begin
                    cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
                    chk(int_addr, b, "R5 addr held");
                    chk(wr_legal, 0, "R5 spent");
                end
                begin
                    int held;
                    held = int_addr;
                    cyc(1'b0, 1'b0, 0, 1'b0, 1'b1);
                    chk(wr_legal, 0, "R9 idle legal");
                    chk(overrun, 0, "R9 idle overrun");
                    chk(int_addr, held, "R9 addr hold");
                    cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
                    chk(int_addr, held, "R11 idle ack");
                end
            end
        end

        // R10 load beats stop and byte_ack
        cyc(1'b1, 1'b1, 8'h20, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
        chk(int_addr, 9'h022, "R10 pre");
        cyc(1'b1, 1'b0, 8'h45, 1'b1, 1'b1);
        chk(int_addr, 9'h045, "R10 load wins addr");
        chk(wr_legal, 1, "R10 load wins state");
        // R10 stop beats byte_ack
        cyc(1'b1, 1'b1, 8'h30, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b1);
        chk(int_addr, 9'h030, "R10 stop drops byte");
        chk(wr_legal, 0, "R10 stop to idle");
        // R10 next page write starts fresh after a stop
        cyc(1'b1, 1'b1, 8'h3E, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
        chk(int_addr, 9'h030, "R4 wrap after restart");
        chk(overrun, 0, "R8 count cleared by load");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule